// File: doc/BRIEF.md
# Asynchronous Serial Adapter

This block connects a processor bus to a single asynchronous serial line. It has one transmitter and one receiver, and each side has a single holding register. The processor sees two addresses, chosen by one select bit. On a write, select 0 is the control byte and select 1 is the character to send. On a read, select 0 is the status byte and select 1 is the last character received.

Bit timing comes from an external bit-rate strobe, `bit_tick`, which is high for one system clock per reference period. A programmable ratio turns this strobe into the line bit rate. The block builds and checks parity, and it flags framing errors and lost characters. It drives a request-to-send output and obeys a clear-to-send input. A single active-high interrupt serves both directions, and software reads the status flags to find which side asked for service.

Top module: `sio_adapter`

## Requirements
- R1: After `rst`, the block is in master reset with control = 0x03. Status reads with only TDRE set, plus the levels of the DCD and CTS inputs. `txd` is high and `irq` is low. Characters arriving on `rxd` are not loaded until software writes a control byte whose bits 1:0 are not 11.
- R2: Register access happens on a cycle with `acc` high. With `wr` high, `rsel`=0 writes the control byte and `rsel`=1 writes the transmit character. With `wr` low, `rsel`=0 reads status and `rsel`=1 reads the received character. Read data appears on `rdata` in the cycle after the access. The status bits are: 0 RDRF, 1 TDRE, 2 DCD, 3 CTS, 4 framing error, 5 overrun, 6 parity error, 7 IRQ.
- R3: Control bits 4:2 choose the character format. 000 is 7 data bits, even parity, 2 stop bits. 001 is 7 bits, odd, 2 stop. 010 is 7 bits, even, 1 stop. 011 is 7 bits, odd, 1 stop. 100 is 8 bits, no parity, 2 stop. 101 is 8 bits, no parity, 1 stop. 110 is 8 bits, even, 1 stop. 111 is 8 bits, odd, 1 stop.
- R4: Control bits 1:0 set how many `bit_tick` strobes make one line bit. 00 gives 1, 01 gives DIV_MID and 10 gives DIV_HI. The code 11 is master reset.
- R5: A written character leaves the line as follows: a low start bit, then the data bits LSB first, then the parity bit if the format has one, then high stop bits. TDRE clears when the character is written. TDRE sets again when the character moves into the shifter.
- R6: While `cts_n` is high, no new character starts. The line stays idle and TDRE stays clear. When `cts_n` goes low, the pending character is sent.
- R7: Control bits 6:5 select the transmit mode. In mode 10, `rts_n` is high. In modes 00, 01 and 11, `rts_n` is low. In mode 11, `txd` is held low (break).
- R8: The receiver looks for a low start bit and checks it again at mid-bit. It then samples each following bit at its centre. When a character is complete, the receiver loads it and sets RDRF. A 7-bit character reads back with bit 7 = 0. Reading the receive register clears RDRF.
- R9: If the received parity bit does not match the selected parity, status bit 6 is set together with the loaded character.
- R10: If the first stop bit is sampled low, status bit 4 is set. The character is still loaded and RDRF is still set.
- R11: If a character completes while RDRF is still set, the overrun bit (status bit 5) is set and the held character is kept. A read of the receive register clears both RDRF and overrun.
- R12: `irq` is high in two cases. The first is when control bit 7 is 1 and RDRF or overrun is set. The second is when transmit mode is 01 and TDRE is set. Status bit 7 reports `irq`.
- R13: Writing 11 to control bits 1:0 has these effects: RDRF, overrun, framing error and parity error clear, TDRE sets, and both shifters return to idle. These flags stay in that state after a normal control byte is written.
- R14: Status bit 2 reads the level of `dcd_n` and status bit 3 reads the level of `cts_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| acc | input | 1 | Register access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| rsel | input | 1 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| bit_tick | input | 1 | External bit-rate strobe, one clock wide |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Request to send, active low |
| cts_n | input | 1 | Clear to send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| irq | output | 1 | Shared interrupt, active high |

## Verification
The bench builds the block with DIV_MID = 4 and DIV_HI = 8, and it pulses `bit_tick` every third clock. With these values, a full 11-bit frame at each of the three ratios takes only a few hundred clocks. This is enough room for many random characters and formats in both directions. The short ratios still keep mid-bit sampling distinct from edge sampling, so a transmitter or receiver that uses the wrong ratio corrupts the captured bits. Ratio 1 is exercised on the receiver, where a bit is one strobe wide.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef struct packed {
    logic dlen8;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } fmt_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_e;

  // Format code from control bits 4:2
  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    f.dlen8    = code[2];
    f.par_en   = !(code == 3'b100 || code == 3'b101);
    f.par_odd  = code[0];
    f.two_stop = (code[2:1] == 2'b00) || (code == 3'b100);
    return f;
  endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] ratio_m1,
  input  fmt_t          fmt,
  input  logic          load,
  input  logic [7:0]    din,
  output logic          busy,
  output logic          line
);

  logic [11:0]   sh;
  logic [3:0]    left;
  logic [CW-1:0] cnt;
  logic [11:0]   frame;
  logic [3:0]    flen;
  logic          par;

  always_comb begin
    par   = (fmt.dlen8 ? ^din : ^din[6:0]) ^ fmt.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    if (fmt.dlen8) begin
      frame[8:1] = din;
      if (fmt.par_en) frame[9] = par;
    end else begin
      frame[7:1] = din[6:0];
      if (fmt.par_en) frame[8] = par;
    end
    flen = 4'd9 + {3'd0, fmt.dlen8} + {3'd0, fmt.par_en} + {3'd0, fmt.two_stop};
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
    end else if (load) begin
      sh   <= frame;
      left <= flen;
      cnt  <= '0;
    end else if (tick && left != 4'd0) begin
      if (cnt == ratio_m1) begin
        cnt  <= '0;
        sh   <= {1'b1, sh[11:1]};
        left <= left - 4'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy = (left != 4'd0);
  assign line = busy ? sh[0] : 1'b1;

endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] ratio_m1,
  input  logic [CW-1:0] half,
  input  logic          dlen8,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rxd,
  output logic          done,
  output logic [7:0]    dout,
  output logic          perr,
  output logic          ferr
);

  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [8:0]    bits;
  logic [3:0]    last;
  logic [7:0]    data_w;
  logic          pbit;

  always_comb begin
    last   = 4'd7 + {3'd0, dlen8} + {3'd0, par_en};
    data_w = dlen8 ? bits[7:0] : {1'b0, bits[6:0]};
    pbit   = dlen8 ? bits[8] : bits[7];
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (clr) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      bits <= '0;
      dout <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else if (tick) begin
      case (st)
        RX_IDLE: begin
          if (!rxd) begin
            cnt <= '0;
            idx <= '0;
            st  <= (half == '0) ? RX_BITS : RX_START;
          end
        end
        RX_START: begin
          if (cnt == half - 1'b1) begin
            cnt <= '0;
            st  <= rxd ? RX_IDLE : RX_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt == ratio_m1) begin
            cnt <= '0;
            if (idx == last) begin
              done <= 1'b1;
              dout <= data_w;
              ferr <= !rxd;
              perr <= par_en && (pbit != ((^data_w) ^ par_odd));
              st   <= RX_IDLE;
            end else begin
              bits[idx] <= rxd;
              idx       <= idx + 4'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sio_adapter.sv
module sio_adapter
  import sio_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc,
  input  logic       wr,
  input  logic       rsel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       bit_tick,
  input  logic       rxd,
  output logic       txd,
  output logic       rts_n,
  input  logic       cts_n,
  input  logic       dcd_n,
  output logic       irq
);

  localparam int CW = $clog2(DIV_HI) + 1;
  localparam logic [CW-1:0] MID_M1  = CW'(DIV_MID - 1);
  localparam logic [CW-1:0] HI_M1   = CW'(DIV_HI - 1);
  localparam logic [CW-1:0] MID_HLF = CW'(DIV_MID / 2);
  localparam logic [CW-1:0] HI_HLF  = CW'(DIV_HI / 2);

  logic [7:0]    ctrl, tdr, rdr, status, rx_data;
  logic          rdrf, tdre, ovr, fe, pe;
  logic          mres, brk, tie, rie, sub_clr;
  fmt_t          fmt;
  logic [CW-1:0] ratio_m1, half;
  logic          wr_ctrl, wr_data, rd_data, tx_load;
  logic          tx_busy, tx_line, rx_done, rx_perr, rx_ferr;

  always_comb begin
    mres = (ctrl[1:0] == 2'b11);
    brk  = (ctrl[6:5] == 2'b11);
    tie  = (ctrl[6:5] == 2'b01);
    rie  = ctrl[7];
    fmt  = decode_fmt(ctrl[4:2]);
    case (ctrl[1:0])
      2'b00: begin ratio_m1 = '0;     half = '0;      end
      2'b01: begin ratio_m1 = MID_M1; half = MID_HLF; end
      default: begin ratio_m1 = HI_M1; half = HI_HLF; end
    endcase
  end

  assign wr_ctrl = acc && wr && !rsel;
  assign wr_data = acc && wr && rsel;
  assign rd_data = acc && !wr && rsel;
  assign tx_load = !tdre && !tx_busy && !cts_n && !mres;
  assign sub_clr = rst || mres;
  assign irq     = (rie && (rdrf || ovr)) || (tie && tdre);
  assign status  = {irq, pe, ovr, fe, cts_n, dcd_n, tdre, rdrf};

  sio_tx #(.CW(CW)) u_tx (
    .clk(clk), .clr(sub_clr), .tick(bit_tick), .ratio_m1(ratio_m1), .fmt(fmt),
    .load(tx_load), .din(tdr), .busy(tx_busy), .line(tx_line)
  );

  sio_rx #(.CW(CW)) u_rx (
    .clk(clk), .clr(sub_clr), .tick(bit_tick), .ratio_m1(ratio_m1), .half(half),
    .dlen8(fmt.dlen8), .par_en(fmt.par_en), .par_odd(fmt.par_odd), .rxd(rxd),
    .done(rx_done), .dout(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= 8'h03;
      rdrf  <= 1'b0;
      tdre  <= 1'b1;
      ovr   <= 1'b0;
      fe    <= 1'b0;
      pe    <= 1'b0;
      tdr   <= '0;
      rdr   <= '0;
      rdata <= '0;
      txd   <= 1'b1;
      rts_n <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= wdata;
      rts_n <= (ctrl[6:5] == 2'b10);
      txd   <= brk ? 1'b0 : tx_line;
      if (acc && !wr) rdata <= rsel ? rdr : status;
      if (mres) begin
        rdrf <= 1'b0;
        ovr  <= 1'b0;
        fe   <= 1'b0;
        pe   <= 1'b0;
        tdre <= 1'b1;
      end else begin
        if (rd_data) begin
          rdrf <= 1'b0;
          ovr  <= 1'b0;
        end
        if (tx_load) tdre <= 1'b1;
        if (wr_data) begin
          tdr  <= wdata;
          tdre <= 1'b0;
        end
        if (rx_done) begin
          if (rdrf && !rd_data) begin
            ovr <= 1'b1;
          end else begin
            rdr  <= rx_data;
            rdrf <= 1'b1;
            fe   <= rx_ferr;
            pe   <= rx_perr;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sio_adapter_chk.sv
module sio_adapter_chk (
  input logic       clk,
  input logic       rst,
  input logic       cts_n,
  input logic       txd,
  input logic       brk,
  input logic       tx_busy,
  input logic       tx_load,
  input logic       wr_data,
  input logic       tdre,
  input logic       rdrf,
  input logic       ovr,
  input logic [7:0] rdr,
  input logic       rx_done,
  input logic       mres
);

  // R13
  mres_clears_chk: assert property (@(posedge clk) disable iff (rst)
    mres |=> (!rdrf && !ovr && tdre));

  // R6
  cts_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cts_n && !tx_busy && !brk) |=> txd);

  // R5
  tdre_refill_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_load && !wr_data) |=> tdre);

  // R11
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $stable(rdr));

  // R8
  rdrf_load_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rdrf && !mres) |=> rdrf);

endmodule

bind sio_adapter sio_adapter_chk u_chk (
  .clk(clk), .rst(rst), .cts_n(cts_n), .txd(txd), .brk(brk), .tx_busy(tx_busy),
  .tx_load(tx_load), .wr_data(wr_data), .tdre(tdre), .rdrf(rdrf), .ovr(ovr),
  .rdr(rdr), .rx_done(rx_done), .mres(mres)
);

// File: tb/sio_adapter_bench.sv
module sio_adapter_bench;

  localparam int MID = 4;
  localparam int HI  = 8;

  logic       clk = 1'b0, rst = 1'b1, acc = 1'b0, wr = 1'b0, rsel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       bit_tick;
  logic       rxd = 1'b1, cts_n = 1'b0, dcd_n = 1'b0;
  logic       txd, rts_n, irq;
  int         total = 0, bad = 0, tk = 0;
  bit         ended = 1'b0;
  event       tick_ev;

  always #4 clk = ~clk;
  always @(negedge clk) tk <= (tk == 2) ? 0 : tk + 1;
  assign bit_tick = (tk == 0);
  always @(posedge clk) if (bit_tick) -> tick_ev;

  sio_adapter #(.DIV_MID(MID), .DIV_HI(HI)) u_sio_adapter (
    .clk(clk), .rst(rst), .acc(acc), .wr(wr), .rsel(rsel), .wdata(wdata),
    .rdata(rdata), .bit_tick(bit_tick), .rxd(rxd), .txd(txd), .rts_n(rts_n),
    .cts_n(cts_n), .dcd_n(dcd_n), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [7:0] d);
    @(negedge clk);
    acc = 1'b1; wr = 1'b1; rsel = s; wdata = d;
    @(negedge clk);
    acc = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic s, output logic [7:0] d);
    @(negedge clk);
    acc = 1'b1; wr = 1'b0; rsel = s;
    @(negedge clk);
    acc = 1'b0;
    d = rdata;
  endtask

  function automatic int ratio(input logic [1:0] dv);
    if (dv == 2'd0) return 1;
    if (dv == 2'd1) return MID;
    return HI;
  endfunction

  // Expected line frame per format code (R3, R5)
  task automatic mk_frame(input logic [7:0] d, input logic [2:0] code, output logic [11:0] f,
                          output int len, output int pidx, output int sidx);
    int dl, ns; bit pen, odd, p;
    case (code)
      3'd0: begin dl = 7; pen = 1; odd = 0; ns = 2; end
      3'd1: begin dl = 7; pen = 1; odd = 1; ns = 2; end
      3'd2: begin dl = 7; pen = 1; odd = 0; ns = 1; end
      3'd3: begin dl = 7; pen = 1; odd = 1; ns = 1; end
      3'd4: begin dl = 8; pen = 0; odd = 0; ns = 2; end
      3'd5: begin dl = 8; pen = 0; odd = 0; ns = 1; end
      3'd6: begin dl = 8; pen = 1; odd = 0; ns = 1; end
      default: begin dl = 8; pen = 1; odd = 1; ns = 1; end
    endcase
    f = '1; f[0] = 1'b0; p = odd;
    for (int i = 0; i < dl; i++) begin f[1+i] = d[i]; p ^= d[i]; end
    pidx = 1 + dl;
    if (pen) f[pidx] = p;
    sidx = 1 + dl + (pen ? 1 : 0);
    len  = sidx + ns;
  endtask

  function automatic logic [7:0] rx_exp(input logic [7:0] d, input logic [2:0] code);
    return code[2] ? d : {1'b0, d[6:0]};
  endfunction

  task automatic send_rx(input logic [7:0] d, input logic [2:0] code, input int n,
                         input bit bad_par, input bit bad_stop);
    logic [11:0] f; int len, pidx, sidx;
    mk_frame(d, code, f, len, pidx, sidx);
    if (bad_par) f[pidx] = ~f[pidx];
    if (bad_stop) f[sidx] = 1'b0;
    @(tick_ev); @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rxd = f[i];
      repeat (n) @(tick_ev);
      @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2) @(tick_ev);
    @(negedge clk);
  endtask

  task automatic cap_tx(input int n, input int len, output logic [11:0] got);
    got = '1;
    while (txd !== 1'b0) @(negedge clk);
    for (int k = 0; k < len; k++) begin
      repeat ((k == 0) ? n / 2 : n) @(tick_ev);
      @(negedge clk); @(negedge clk);
      got[k] = txd;
    end
  endtask

  task automatic tx_check(input logic [7:0] d, input logic [2:0] code, input logic [1:0] dv,
                          input string req);
    logic [11:0] f, got; int len, pidx, sidx, n;
    n = ratio(dv);
    mk_frame(d, code, f, len, pidx, sidx);
    wr_reg(1'b1, d);
    cap_tx(n, len, got);
    chk(req, 32'(got & 12'((1 << len) - 1)), 32'(f & 12'((1 << len) - 1)));
    repeat (n + 2) @(tick_ev);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] s, d;
    logic [2:0] code;
    logic [1:0] dv;
    void'($urandom(32'h1d5e_a7c3));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd_reg(1'b0, s);
    chk("R1 status after reset", s, 8'h02);
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 irq low", irq, 1'b0);
    send_rx(8'h5A, 3'd5, HI, 0, 0);
    rd_reg(1'b0, s);
    chk("R1 no load in master reset", s[0], 1'b0);

    // R2 R3 R5 transmit 8N1 ratio MID
    wr_reg(1'b0, 8'h15);
    rd_reg(1'b0, s);
    chk("R2 status after setup", s, 8'h02);
    tx_check(8'hA5, 3'd5, 2'd1, "R5 tx 8N1");
    rd_reg(1'b0, s);
    chk("R5 TDRE set after send", s[1], 1'b1);

    // R3 R4 7E1 at ratio HI
    wr_reg(1'b0, 8'h0A);
    tx_check(8'h41, 3'd2, 2'd2, "R4 tx 7E1 ratio HI");

    // R3 R5 random transmit
    for (int i = 0; i < 6; i++) begin
      code = 3'($urandom % 8);
      dv   = 2'(1 + $urandom % 2);
      wr_reg(1'b0, {3'b000, code, dv});
      tx_check(8'($urandom), code, dv, "R3 tx random format");
    end

    // R8 receive 8N1 ratio MID
    wr_reg(1'b0, 8'h15);
    send_rx(8'h3C, 3'd5, MID, 0, 0);
    rd_reg(1'b0, s);
    chk("R8 RDRF set", s[0], 1'b1);
    rd_reg(1'b1, d);
    chk("R8 rx data", d, 8'h3C);
    rd_reg(1'b0, s);
    chk("R8 RDRF cleared by read", s[0], 1'b0);

    // R4 ratio 1, 7O1
    wr_reg(1'b0, {3'b000, 3'd3, 2'd0});
    send_rx(8'hD5, 3'd3, 1, 0, 0);
    rd_reg(1'b1, d);
    chk("R4 rx ratio 1 7-bit", d, 8'h55);

    // R3 R8 random receive
    for (int i = 0; i < 8; i++) begin
      logic [7:0] rv;
      code = 3'($urandom % 8);
      dv   = 2'($urandom % 3);
      rv   = 8'($urandom);
      wr_reg(1'b0, {3'b000, code, dv});
      send_rx(rv, code, ratio(dv), 0, 0);
      rd_reg(1'b0, s);
      chk("R8 random rx flags", {s[6], s[5], s[4], s[0]}, 4'b0001);
      rd_reg(1'b1, d);
      chk("R3 random rx data", d, rx_exp(rv, code));
    end

    // R9 parity error
    wr_reg(1'b0, {3'b000, 3'd6, 2'd1});
    send_rx(8'h81, 3'd6, MID, 1, 0);
    rd_reg(1'b0, s);
    chk("R9 parity error flag", {s[6], s[0]}, 2'b11);
    rd_reg(1'b1, d);
    send_rx(8'h81, 3'd6, MID, 0, 0);
    rd_reg(1'b0, s);
    chk("R9 parity clean next char", s[6], 1'b0);
    rd_reg(1'b1, d);

    // R10 framing error
    wr_reg(1'b0, 8'h15);
    send_rx(8'h7E, 3'd5, MID, 0, 1);
    rd_reg(1'b0, s);
    chk("R10 framing flag and RDRF", {s[4], s[0]}, 2'b11);
    rd_reg(1'b1, d);
    chk("R10 char still loaded", d, 8'h7E);

    // R11 overrun
    send_rx(8'h11, 3'd5, MID, 0, 0);
    send_rx(8'h22, 3'd5, MID, 0, 0);
    rd_reg(1'b0, s);
    chk("R11 overrun set", {s[5], s[0]}, 2'b11);
    rd_reg(1'b1, d);
    chk("R11 first char kept", d, 8'h11);
    rd_reg(1'b0, s);
    chk("R11 cleared by read", {s[5], s[0]}, 2'b00);

    // R12 interrupt
    wr_reg(1'b0, 8'h95);
    @(negedge clk);
    chk("R12 irq idle", irq, 1'b0);
    send_rx(8'h66, 3'd5, MID, 0, 0);
    rd_reg(1'b0, s);
    chk("R12 irq on rx full", {irq, s[7]}, 2'b11);
    rd_reg(1'b1, d);
    @(negedge clk);
    chk("R12 irq drops after read", irq, 1'b0);
    wr_reg(1'b0, 8'h35);
    @(negedge clk);
    chk("R12 irq on tx empty", irq, 1'b1);

    // R6 R14 clear to send
    wr_reg(1'b0, 8'h15);
    cts_n = 1'b1;
    rd_reg(1'b0, s);
    chk("R14 CTS bit", s[3], 1'b1);
    wr_reg(1'b1, 8'hC3);
    repeat (60) @(negedge clk);
    chk("R6 line idle while CTS high", txd, 1'b1);
    rd_reg(1'b0, s);
    chk("R6 TDRE held clear", s[1], 1'b0);
    cts_n = 1'b0;
    begin
      logic [11:0] f, got; int len, pidx, sidx;
      mk_frame(8'hC3, 3'd5, f, len, pidx, sidx);
      cap_tx(MID, len, got);
      chk("R6 sends after CTS low", 32'(got[9:0]), 32'(f[9:0]));
      repeat (MID + 2) @(tick_ev);
    end

    // R14 carrier detect
    dcd_n = 1'b1;
    rd_reg(1'b0, s);
    chk("R14 DCD bit", s[2], 1'b1);
    dcd_n = 1'b0;

    // R7 RTS and break
    wr_reg(1'b0, 8'h55);
    @(negedge clk);
    chk("R7 rts high mode 10", rts_n, 1'b1);
    wr_reg(1'b0, 8'h75);
    repeat (2) @(negedge clk);
    chk("R7 break drives low", {rts_n, txd}, 2'b00);
    wr_reg(1'b0, 8'h15);
    repeat (2) @(negedge clk);
    chk("R7 break released", {rts_n, txd}, 2'b01);

    // R13 master reset
    send_rx(8'h99, 3'd5, MID, 0, 0);
    send_rx(8'h98, 3'd5, MID, 0, 0);
    wr_reg(1'b0, 8'h03);
    wr_reg(1'b0, 8'h15);
    rd_reg(1'b0, s);
    chk("R13 flags cleared", s, 8'h02);

    finish_run();
  end

endmodule